// File: doc/BRIEF.md
# Per-line coherence controller for a private first-level cache

This block keeps the coherence state of a single line of a private first-level cache that sits under a shared second-level directory. It uses a four-state invalidation protocol (modified, exclusive, shared, invalid) and adds a separate not-present state. An external dispatcher picks one event per cycle for the line and presents it on `ev_code` with `ev_valid`. Events include processor accesses, prefetch accesses, requests forwarded from the directory, invalidations, classified fill and acknowledgement responses, and the writeback acknowledgement. The controller computes the next state. It answers with message commands, completion (hit) pulses, and a stall pulse. The stall pulse tells the dispatcher to hold the event and replay it later.

Events are single-cycle strobes, and every strobed event is consumed in its cycle. There is no ready signal. Back-pressure is expressed only through `stall`: a stalled event leaves the line untouched, and the dispatcher must offer it again. All results appear one cycle after the event as one-cycle pulses.

The data array, the message buffers and the arithmetic on acknowledgement counts stay outside the block. The dispatcher tells it whether a fill or acknowledgement is the last one it needs.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 (absent), every pulse output is low and `err` is 0. State codes are: absent 0, invalid 1, shared 2, exclusive 3, modified 4, read-wait 5, write-wait 6, upgrade-wait 7, read-wait-killed 8, evicting 9, draining 10, prefetch read-wait 11, prefetch write-wait 12, prefetch upgrade-wait 13, prefetch read-wait-killed 14.
- R2: When the line is absent or invalid, three demand misses each send one request with `msg_dest`=2'b10 (bit 1 selects the directory, bit 0 the original requestor). A load (event 0) goes to read-wait with `msg_kind` 1 (shared read). An instruction fetch (event 1) goes to read-wait with `msg_kind` 2 (instruction read). A store (event 2) goes to write-wait with `msg_kind` 3 (exclusive read).
- R3: A store in shared sends `msg_kind` 4 (upgrade) to the directory and moves to upgrade-wait. A store in exclusive or modified raises `hit`, sends no message and leaves the line modified and dirty.
- R4: A replacement (event 3) in exclusive or modified sends `msg_kind` 5 (writeback) to the directory and moves to evicting. `msg_wb_data` is 1 only when the line is dirty. In shared, a replacement moves to invalid with no message.
- R5: An invalidation (event 10) works as follows. In modified it sends data (`msg_kind` 6) to the directory. In exclusive or shared it sends an ack (`msg_kind` 7) to the requestor. In each case the line ends invalid. In exclusive or modified, a forwarded shared or instruction read (events 7, 8) sends data to both destinations and moves to shared. A forwarded exclusive read (event 9) sends data to the requestor and moves to invalid.
- R6: In evicting, an invalidation or forwarded request is answered with data as in R5 and the line moves to draining. Draining, like evicting, returns to invalid only on the writeback ack (event 17).
- R7: An invalidation in read-wait sends an ack and moves to read-wait-killed. A later fill still raises `hit`. The line then ends invalid, or exclusive if the fill is exclusive.
- R8: In a read wait, an exclusive fill (event 12) moves to exclusive and raises `unblk_valid` with `unblk_excl`. A shared fill from a peer cache (event 13) moves to shared and raises `unblk_valid` alone. A final fill from the directory (event 14) moves to shared with no unblock.
- R9: In any transient state, a demand load, fetch, store or replacement that is not converted under R10 raises `stall`. It then sends nothing, raises no `hit`, and leaves the state unchanged.
- R10: A prefetch load, fetch or store (events 4, 5, 6) from absent or invalid issues the same request as R2 and enters the prefetch form of the wait state. In any other state a prefetch has no effect. A matching demand access to a prefetch wait state converts it to the demand form with no message and no stall. A load or fetch matches the read waits; a store matches the write and upgrade waits.
- R11: An event that is not legal in the current state sets `err`, leaves the state unchanged and sends nothing. `err` stays set until reset.
- R12: All outputs change one cycle after the event is strobed and stay high for one cycle only. `hit` and `msg_valid` are never high together.
- R13: In write-wait, a partial fill (event 11) moves to upgrade-wait. Partial acks (event 15) keep upgrade-wait. The final ack (event 16) or final fill completes the store: `hit`, exclusive unblock, dirty modified. An invalidation in upgrade-wait sends an ack and falls back to write-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_code | input | 5 | Event code (0 load, 1 fetch, 2 store, 3 replace, 4-6 prefetch load/fetch/store, 7-9 forwarded shared/instr/exclusive read, 10 invalidate, 11 partial fill, 12 exclusive fill, 13 peer shared fill, 14 final fill, 15 partial ack, 16 final ack, 17 writeback ack) |
| line_state | output | 4 | Current line state code |
| msg_valid | output | 1 | Message command pulse |
| msg_kind | output | 3 | Message type code |
| msg_dest | output | 2 | Destination mask: bit 0 requestor, bit 1 directory |
| msg_wb_data | output | 1 | Writeback carries data (dirty line) |
| unblk_valid | output | 1 | Unblock pulse to the directory |
| unblk_excl | output | 1 | Unblock is the exclusive kind |
| hit | output | 1 | Processor access completed |
| stall | output | 1 | Event must be replayed |
| err | output | 1 | Sticky illegal-event flag |

## Verification
Several functions can land in the same output cycle. When a fill ends a demand read, the completion pulse to the processor and the unblock to the directory rise together with the state change. When a demand access meets a prefetch wait, the conversion must happen without the stall that every other transient state would give. The bench provokes both by placing a fill right after a read miss, and a demand load or store right after a prefetch. Every output field is compared against the expected record in that one cycle, so a missing or extra pulse on either side shows as a mismatch.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int ST_W  = 4;
  localparam int EV_W  = 5;
  localparam int MSG_W = 3;
  localparam int DST_W = 2;

  localparam logic [DST_W-1:0] DST_REQ = 2'b01;
  localparam logic [DST_W-1:0] DST_L2  = 2'b10;

  typedef enum logic [ST_W-1:0] {
    ST_ABSENT, ST_INV, ST_SHR, ST_EXC, ST_MOD,
    ST_WAIT_RD, ST_WAIT_WR, ST_WAIT_UPG, ST_WAIT_RD_KILL,
    ST_EVICT, ST_DRAIN,
    ST_PF_RD, ST_PF_WR, ST_PF_UPG, ST_PF_RD_KILL
  } st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LD, EV_IF, EV_ST, EV_EVICT,
    EV_PF_LD, EV_PF_IF, EV_PF_ST,
    EV_FWD_SHR, EV_FWD_INSTR, EV_FWD_EXCL, EV_INVAL,
    EV_FILL_PART, EV_FILL_EXCL, EV_FILL_PEER, EV_FILL_DONE,
    EV_ACK_PART, EV_ACK_DONE, EV_WB_DONE
  } ev_e;

  typedef enum logic [MSG_W-1:0] {
    MSG_NONE, MSG_RD_SHR, MSG_RD_INSTR, MSG_RD_EXCL,
    MSG_UPGRADE, MSG_WRBACK, MSG_DATA, MSG_ACK
  } msg_e;

  typedef struct packed {
    st_e              nxt;
    logic             mv;
    msg_e             mk;
    logic [DST_W-1:0] md;
    logic             wbd;
    logic             uv;
    logic             ux;
    logic             hit;
    logic             stall;
    logic             bad;
    logic             dset;
  } act_t;
endpackage

// File: rtl/coh_xition.sv
module coh_xition
  import coh_pkg::*;
(
  input  st_e  cur,
  input  ev_e  ev,
  input  logic dirty,
  output act_t act
);
  logic is_dem, is_pf, busy, kill, pf;

  always_comb begin
    is_dem = (ev == EV_LD) || (ev == EV_IF) || (ev == EV_ST) || (ev == EV_EVICT);
    is_pf  = (ev == EV_PF_LD) || (ev == EV_PF_IF) || (ev == EV_PF_ST);
    busy   = !((cur == ST_ABSENT) || (cur == ST_INV) || (cur == ST_SHR) ||
               (cur == ST_EXC) || (cur == ST_MOD));
    kill   = (cur == ST_WAIT_RD_KILL) || (cur == ST_PF_RD_KILL);
    pf     = (cur == ST_PF_RD) || (cur == ST_PF_WR) || (cur == ST_PF_UPG) ||
             (cur == ST_PF_RD_KILL);
  end

  always_comb begin
    act     = '0;
    act.nxt = cur;
    if (is_dem && busy) begin
      if ((ev == EV_LD || ev == EV_IF) && cur == ST_PF_RD)           act.nxt = ST_WAIT_RD;
      else if ((ev == EV_LD || ev == EV_IF) && cur == ST_PF_RD_KILL) act.nxt = ST_WAIT_RD_KILL;
      else if (ev == EV_ST && cur == ST_PF_WR)                       act.nxt = ST_WAIT_WR;
      else if (ev == EV_ST && cur == ST_PF_UPG)                      act.nxt = ST_WAIT_UPG;
      else                                                           act.stall = 1'b1;
    end else if (is_pf && !(cur == ST_ABSENT || cur == ST_INV)) begin
      act.nxt = cur;
    end else begin
      case (cur)
        ST_ABSENT, ST_INV: begin
          act.md = DST_L2;
          case (ev)
            EV_LD:    begin act.nxt = ST_WAIT_RD; act.mv = 1'b1; act.mk = MSG_RD_SHR;   end
            EV_IF:    begin act.nxt = ST_WAIT_RD; act.mv = 1'b1; act.mk = MSG_RD_INSTR; end
            EV_ST:    begin act.nxt = ST_WAIT_WR; act.mv = 1'b1; act.mk = MSG_RD_EXCL;  end
            EV_PF_LD: begin act.nxt = ST_PF_RD;   act.mv = 1'b1; act.mk = MSG_RD_SHR;   end
            EV_PF_IF: begin act.nxt = ST_PF_RD;   act.mv = 1'b1; act.mk = MSG_RD_INSTR; end
            EV_PF_ST: begin act.nxt = ST_PF_WR;   act.mv = 1'b1; act.mk = MSG_RD_EXCL;  end
            EV_INVAL: begin act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ; end
            EV_EVICT: begin
              act.md = '0;
              if (cur == ST_INV) act.nxt = ST_ABSENT;
              else               act.bad = 1'b1;
            end
            default:  begin act.bad = 1'b1; act.md = '0; end
          endcase
        end
        ST_SHR: begin
          case (ev)
            EV_LD, EV_IF: act.hit = 1'b1;
            EV_ST:    begin act.nxt = ST_WAIT_UPG; act.mv = 1'b1; act.mk = MSG_UPGRADE; act.md = DST_L2; end
            EV_EVICT: act.nxt = ST_INV;
            EV_INVAL: begin act.nxt = ST_INV; act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ; end
            default:  act.bad = 1'b1;
          endcase
        end
        ST_EXC, ST_MOD: begin
          case (ev)
            EV_LD, EV_IF: act.hit = 1'b1;
            EV_ST:    begin act.nxt = ST_MOD; act.hit = 1'b1; act.dset = 1'b1; end
            EV_EVICT: begin
              act.nxt = ST_EVICT; act.mv = 1'b1; act.mk = MSG_WRBACK;
              act.md = DST_L2; act.wbd = dirty;
            end
            EV_INVAL: begin
              act.nxt = ST_INV; act.mv = 1'b1;
              if (cur == ST_MOD) begin act.mk = MSG_DATA; act.md = DST_L2;  end
              else               begin act.mk = MSG_ACK;  act.md = DST_REQ; end
            end
            EV_FWD_SHR, EV_FWD_INSTR: begin
              act.nxt = ST_SHR; act.mv = 1'b1; act.mk = MSG_DATA; act.md = DST_REQ | DST_L2;
            end
            EV_FWD_EXCL: begin act.nxt = ST_INV; act.mv = 1'b1; act.mk = MSG_DATA; act.md = DST_REQ; end
            default:  act.bad = 1'b1;
          endcase
        end
        ST_WAIT_RD, ST_WAIT_RD_KILL, ST_PF_RD, ST_PF_RD_KILL: begin
          case (ev)
            EV_INVAL: begin
              if (kill) act.bad = 1'b1;
              else begin
                act.nxt = pf ? ST_PF_RD_KILL : ST_WAIT_RD_KILL;
                act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ;
              end
            end
            EV_FILL_EXCL: begin act.nxt = ST_EXC; act.hit = !pf; act.uv = 1'b1; act.ux = 1'b1; end
            EV_FILL_PEER: begin act.nxt = kill ? ST_INV : ST_SHR; act.hit = !pf; act.uv = 1'b1; end
            EV_FILL_DONE: begin act.nxt = kill ? ST_INV : ST_SHR; act.hit = !pf; end
            default:      act.bad = 1'b1;
          endcase
        end
        ST_WAIT_WR, ST_PF_WR: begin
          case (ev)
            EV_INVAL:     begin act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ; end
            EV_FILL_PART: act.nxt = pf ? ST_PF_UPG : ST_WAIT_UPG;
            EV_FILL_DONE: begin
              act.nxt = ST_MOD; act.hit = !pf; act.dset = !pf; act.uv = 1'b1; act.ux = 1'b1;
            end
            default:      act.bad = 1'b1;
          endcase
        end
        ST_WAIT_UPG, ST_PF_UPG: begin
          case (ev)
            EV_INVAL: begin
              act.nxt = pf ? ST_PF_WR : ST_WAIT_WR;
              act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ;
            end
            EV_ACK_PART, EV_FILL_PART: act.nxt = cur;
            EV_ACK_DONE, EV_FILL_DONE: begin
              act.nxt = ST_MOD; act.hit = !pf; act.dset = !pf; act.uv = 1'b1; act.ux = 1'b1;
            end
            default: act.bad = 1'b1;
          endcase
        end
        ST_EVICT: begin
          case (ev)
            EV_INVAL:    begin act.nxt = ST_DRAIN; act.mv = 1'b1; act.mk = MSG_DATA; act.md = DST_L2; end
            EV_FWD_SHR, EV_FWD_INSTR: begin
              act.nxt = ST_DRAIN; act.mv = 1'b1; act.mk = MSG_DATA; act.md = DST_REQ | DST_L2;
            end
            EV_FWD_EXCL: begin act.nxt = ST_DRAIN; act.mv = 1'b1; act.mk = MSG_DATA; act.md = DST_REQ; end
            EV_WB_DONE:  act.nxt = ST_INV;
            default:     act.bad = 1'b1;
          endcase
        end
        ST_DRAIN: begin
          case (ev)
            EV_WB_DONE: act.nxt = ST_INV;
            EV_INVAL:   begin act.mv = 1'b1; act.mk = MSG_ACK; act.md = DST_REQ; end
            default:    act.bad = 1'b1;
          endcase
        end
        default: act.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_regs.sv
module coh_line_regs
  import coh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  act_t act,
  output st_e  state,
  output logic dirty,
  output logic err
);
  logic keep_dirty;
  assign keep_dirty = (act.nxt == ST_MOD) || (act.nxt == ST_EVICT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_ABSENT;
      dirty <= 1'b0;
      err   <= 1'b0;
    end else if (valid) begin
      state <= act.nxt;
      if (act.dset)        dirty <= 1'b1;
      else if (!keep_dirty) dirty <= 1'b0;
      if (act.bad)         err <= 1'b1;
    end
  end

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_DRAIN && state != ST_DRAIN) |-> state == ST_INV);

  p_dirty_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> (state == ST_MOD || state == ST_EVICT));
endmodule

// File: rtl/coh_out_reg.sv
module coh_out_reg
  import coh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  act_t             act,
  output logic             msg_valid,
  output msg_e             msg_kind,
  output logic [DST_W-1:0] msg_dest,
  output logic             msg_wb_data,
  output logic             unblk_valid,
  output logic             unblk_excl,
  output logic             hit,
  output logic             stall
);
  always_ff @(posedge clk) begin
    if (!rst_n || !valid) begin
      msg_valid   <= 1'b0;
      msg_kind    <= MSG_NONE;
      msg_dest    <= '0;
      msg_wb_data <= 1'b0;
      unblk_valid <= 1'b0;
      unblk_excl  <= 1'b0;
      hit         <= 1'b0;
      stall       <= 1'b0;
    end else begin
      msg_valid   <= act.mv;
      msg_kind    <= act.mv ? act.mk : MSG_NONE;
      msg_dest    <= act.mv ? act.md : '0;
      msg_wb_data <= act.mv & act.wbd;
      unblk_valid <= act.uv;
      unblk_excl  <= act.uv & act.ux;
      hit         <= act.hit;
      stall       <= act.stall;
    end
  end

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!msg_valid && !hit && !unblk_valid));

  p_hit_no_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !msg_valid);

  p_excl_needs_unblk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_excl |-> unblk_valid);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [EV_W-1:0]  ev_code,
  output logic [ST_W-1:0]  line_state,
  output logic             msg_valid,
  output logic [MSG_W-1:0] msg_kind,
  output logic [DST_W-1:0] msg_dest,
  output logic             msg_wb_data,
  output logic             unblk_valid,
  output logic             unblk_excl,
  output logic             hit,
  output logic             stall,
  output logic             err
);
  st_e  cur;
  logic dirty;
  act_t act;
  msg_e kind_q;

  coh_xition u_xition (
    .cur   (cur),
    .ev    (ev_e'(ev_code)),
    .dirty (dirty),
    .act   (act)
  );

  coh_line_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (ev_valid),
    .act   (act),
    .state (cur),
    .dirty (dirty),
    .err   (err)
  );

  coh_out_reg u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (ev_valid),
    .act         (act),
    .msg_valid   (msg_valid),
    .msg_kind    (kind_q),
    .msg_dest    (msg_dest),
    .msg_wb_data (msg_wb_data),
    .unblk_valid (unblk_valid),
    .unblk_excl  (unblk_excl),
    .hit         (hit),
    .stall       (stall)
  );

  assign line_state = cur;
  assign msg_kind   = kind_q;

  p_stall_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> line_state == $past(line_state));
endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;
  import coh_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [EV_W-1:0] ev_code = '0;
  logic [ST_W-1:0] line_state;
  logic msg_valid, msg_wb_data, unblk_valid, unblk_excl, hit, stall, err;
  logic [MSG_W-1:0] msg_kind;
  logic [DST_W-1:0] msg_dest;

  always #5 clk = ~clk;

  coh_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .line_state(line_state), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_wb_data(msg_wb_data), .unblk_valid(unblk_valid),
    .unblk_excl(unblk_excl), .hit(hit), .stall(stall), .err(err)
  );

  typedef struct {
    logic [17:0] vec;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic done = 1'b0;
  logic exp_err = 1'b0;

  // expected vector: state, mv, kind, dest, wbd, uv, ux, hit, stall, err
  function automatic logic [17:0] pack(st_e s, logic mv, msg_e k, logic [1:0] d,
                                       logic w, logic uv, logic ux, logic h,
                                       logic st, logic e);
    return {s, mv, k, d, w, uv, ux, h, st, e};
  endfunction

  task automatic step(input logic v, input ev_e code, input st_e ns,
                      input logic mv, input msg_e k, input logic [1:0] d,
                      input logic w, input logic uv, input logic ux,
                      input logic h, input logic st, input string tag);
    exp_t e;
    @(negedge clk);
    ev_valid = v;
    ev_code  = code;
    e.vec = pack(ns, mv, k, d, w, uv, ux, h, st, exp_err);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input st_e s, input string tag);
    step(1'b0, EV_LD, s, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: results of an event strobed before edge k are sampled 2 ns after edge k
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [17:0] got;
      e = q.pop_front();
      got = {line_state, msg_valid, msg_kind, msg_dest, msg_wb_data,
             unblk_valid, unblk_excl, hit, stall, err};
      n_chk++;
      if (got !== e.vec) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.tag, got, e.vec);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(ST_ABSENT, "R1 reset state");
    step(1, EV_LD,  ST_WAIT_RD, 1, MSG_RD_SHR, DST_L2, 0, 0, 0, 0, 0, "R2 load miss");
    step(1, EV_LD,  ST_WAIT_RD, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 1, "R9 stall in read wait");
    step(1, EV_FILL_EXCL, ST_EXC, 0, MSG_NONE, 2'b00, 0, 1, 1, 1, 0, "R8 exclusive fill");
    idle(ST_EXC, "R12 pulses drop");
    step(1, EV_ST,  ST_MOD, 0, MSG_NONE, 2'b00, 0, 0, 0, 1, 0, "R3 store hit in E");
    step(1, EV_EVICT, ST_EVICT, 1, MSG_WRBACK, DST_L2, 1, 0, 0, 0, 0, "R4 dirty writeback");
    step(1, EV_LD,  ST_EVICT, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 1, "R9 stall in evicting");
    step(1, EV_FWD_EXCL, ST_DRAIN, 1, MSG_DATA, DST_REQ, 0, 0, 0, 0, 0, "R6 answer from evicting");
    step(1, EV_ST,  ST_DRAIN, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 1, "R6 draining holds");
    step(1, EV_WB_DONE, ST_INV, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R6 writeback ack");
    step(1, EV_IF,  ST_WAIT_RD, 1, MSG_RD_INSTR, DST_L2, 0, 0, 0, 0, 0, "R2 fetch miss");
    step(1, EV_INVAL, ST_WAIT_RD_KILL, 1, MSG_ACK, DST_REQ, 0, 0, 0, 0, 0, "R7 inval overtakes fill");
    step(1, EV_FILL_PEER, ST_INV, 0, MSG_NONE, 2'b00, 0, 1, 0, 1, 0, "R7 killed fill ends invalid");
    step(1, EV_ST,  ST_WAIT_WR, 1, MSG_RD_EXCL, DST_L2, 0, 0, 0, 0, 0, "R2 store miss");
    step(1, EV_FILL_PART, ST_WAIT_UPG, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R13 partial fill");
    step(1, EV_ACK_PART, ST_WAIT_UPG, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R13 partial ack");
    step(1, EV_ACK_DONE, ST_MOD, 0, MSG_NONE, 2'b00, 0, 1, 1, 1, 0, "R13 final ack");
    step(1, EV_FWD_SHR, ST_SHR, 1, MSG_DATA, DST_REQ | DST_L2, 0, 0, 0, 0, 0, "R5 forwarded shared read");
    step(1, EV_PF_LD, ST_SHR, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R10 prefetch discarded");
    step(1, EV_ST,  ST_WAIT_UPG, 1, MSG_UPGRADE, DST_L2, 0, 0, 0, 0, 0, "R3 upgrade from shared");
    step(1, EV_INVAL, ST_WAIT_WR, 1, MSG_ACK, DST_REQ, 0, 0, 0, 0, 0, "R13 inval in upgrade wait");
    step(1, EV_FILL_DONE, ST_MOD, 0, MSG_NONE, 2'b00, 0, 1, 1, 1, 0, "R13 final fill");
    step(1, EV_INVAL, ST_INV, 1, MSG_DATA, DST_L2, 0, 0, 0, 0, 0, "R5 inval in modified");
    step(1, EV_PF_ST, ST_PF_WR, 1, MSG_RD_EXCL, DST_L2, 0, 0, 0, 0, 0, "R10 prefetch store");
    step(1, EV_ST,  ST_WAIT_WR, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R10 demand converts");
    step(1, EV_FILL_DONE, ST_MOD, 0, MSG_NONE, 2'b00, 0, 1, 1, 1, 0, "R13 store done");
    step(1, EV_FWD_INSTR, ST_SHR, 1, MSG_DATA, DST_REQ | DST_L2, 0, 0, 0, 0, 0, "R5 forwarded instr read");
    step(1, EV_EVICT, ST_INV, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R4 silent shared drop");
    step(1, EV_PF_LD, ST_PF_RD, 1, MSG_RD_SHR, DST_L2, 0, 0, 0, 0, 0, "R10 prefetch load");
    step(1, EV_INVAL, ST_PF_RD_KILL, 1, MSG_ACK, DST_REQ, 0, 0, 0, 0, 0, "R7 inval on prefetch");
    step(1, EV_LD,  ST_WAIT_RD_KILL, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R10 load converts");
    step(1, EV_FILL_EXCL, ST_EXC, 0, MSG_NONE, 2'b00, 0, 1, 1, 1, 0, "R7 killed exclusive fill");
    step(1, EV_EVICT, ST_EVICT, 1, MSG_WRBACK, DST_L2, 0, 0, 0, 0, 0, "R4 clean writeback");
    step(1, EV_INVAL, ST_DRAIN, 1, MSG_DATA, DST_L2, 0, 0, 0, 0, 0, "R6 inval in evicting");
    step(1, EV_WB_DONE, ST_INV, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R6 drain exit");
    exp_err = 1'b1;
    step(1, EV_FILL_PART, ST_INV, 0, MSG_NONE, 2'b00, 0, 0, 0, 0, 0, "R11 illegal event");
    idle(ST_INV, "R11 error sticky");
    step(1, EV_LD,  ST_WAIT_RD, 1, MSG_RD_SHR, DST_L2, 0, 0, 0, 0, 0, "R11 error kept after load");
    step(1, EV_FILL_DONE, ST_SHR, 0, MSG_NONE, 2'b00, 0, 0, 0, 1, 0, "R8 directory fill no unblock");
    idle(ST_SHR, "R12 quiet after fill");
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule